// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of chip-level control and status registers reached over a plain 32-bit register bus with four signals: a byte address, a write strobe, write data and read data. Reads are combinational and always allowed. Writes to the control registers only take effect after software has opened the bank. It opens the bank by writing two fixed keys, in order, to a pair of kick registers.

On top of that gate, the device-control register has its own lock register and key. A configuration register captures only the first write it accepts. One device field can be switched on but never switched off again. The bank also returns a read-only silicon revision and a MAC address taken from fuse values, both of which arrive on input ports. It drives per-device enable lines, an Ethernet RMII reset line and a sticky flag that records rejected writes.

Top module: `cfg_guard_bank`

## Requirements
- R1: Reset does the following: puts the kick gate in the locked state, clears every device field (all `dev_en` low, `fix_en` low), clears `rmii_rst`, clears `wr_err`, and makes the write-once register writable again.
- R2: After 0x83E70B13 is written to offset 0x38 and then 0x95A4F1E0 is written to offset 0x3C, the bank is open and writes to protected registers take effect.
- R3: Any of the following returns the gate to locked: a wrong value written to 0x38, a wrong value written to 0x3C, or a write to 0x3C without a correct 0x38 write just before it.
- R4: While the gate is locked, writes to the protected registers (0x40004, 0x40008, 0x40020, 0x4002C) are dropped and set `wr_err`. Reads of every register still return data.
- R5: The device-control register at 0x40008 accepts a write only while the gate is open and the lock register at 0x40004 holds 0x0F0A0B00. Otherwise the write is rejected. The lock register reads back the value written to it.
- R6: Device i (0 to 11) owns the 2-bit field at bits [2i+1:2i] of 0x40008. `dev_en[i]` is high exactly when that field holds 1. The field reads back as written.
- R7: The field at bits [31:30] of 0x40008 enables the extra device with code 3 and cannot be disabled. Writing any other value to it is ignored, and `fix_en` stays high once set.
- R8: The 8-bit register at 0x4002C (bits [7:0]) keeps the value of its first accepted write. Later writes have no effect on it and set `wr_err`.
- R9: Offset 0x008 reads `silicon_rev` in bits [31:28] with all other bits zero. Writes to it have no effect.
- R10: Offset 0x700 reads MAC bytes 1 to 4, with byte 1 (`mac_fuse[47:40]`) in bits [31:24]. Offset 0x704 reads bytes 5 and 6 in bits [31:16] and zero in bits [15:0].
- R11: Bit 18 of 0x40020 drives `rmii_rst`. It is writable only while the gate is open, and all other bits of that register read zero.
- R12: `wr_err` rises after a rejected protected write. It stays high until a protected write is accepted, which clears it. Writes to the kick registers or to read-only registers do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| silicon_rev | input | 4 | Silicon revision value |
| mac_fuse | input | 48 | MAC address fuses, byte 1 in the top byte |
| dev_en | output | 12 | Per-device enable |
| fix_en | output | 1 | Enable of the device that cannot be disabled |
| rmii_rst | output | 1 | Ethernet RMII reset control |
| wo_cfg | output | 8 | Write-once configuration value |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The kick gate is exercised with four patterns:
- the correct pair of keys;
- the second key written first;
- a wrong first key;
- a wrong key written after the gate has opened.

Each pattern is followed by a probe write to the RMII register, so a working sequence and each kind of broken sequence are told apart at `rmii_rst`. The device-control register receives three data patterns with mixed field codes. These separate the enable code from other codes, and a cleared extra-device field shows the no-disable rule. A write with the lock key removed shows that the second gate works independently of the first. The write-once register is written twice, and written again after a reset, which shows both the freeze and its release.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  localparam int unsigned AW = 20;

  localparam logic [AW-1:0] OFF_REV    = 20'h00008;
  localparam logic [AW-1:0] OFF_KICK0  = 20'h00038;
  localparam logic [AW-1:0] OFF_KICK1  = 20'h0003C;
  localparam logic [AW-1:0] OFF_MAC0   = 20'h00700;
  localparam logic [AW-1:0] OFF_MAC1   = 20'h00704;
  localparam logic [AW-1:0] OFF_LOCK   = 20'h40004;
  localparam logic [AW-1:0] OFF_DEVCTL = 20'h40008;
  localparam logic [AW-1:0] OFF_RMII   = 20'h40020;
  localparam logic [AW-1:0] OFF_ONCE   = 20'h4002C;

  localparam logic [31:0] KEY_FIRST  = 32'h83E70B13;
  localparam logic [31:0] KEY_SECOND = 32'h95A4F1E0;
  localparam logic [31:0] LOCK_KEY   = 32'h0F0A0B00;
  localparam int unsigned RMII_BIT   = 18;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} kick_st_e;

  // Next state of the two-step kick gate for one bus cycle.
  function automatic kick_st_e kick_next(kick_st_e cur, logic hit0, logic hit1,
                                         logic [31:0] d);
    kick_next = cur;
    if (hit0)      kick_next = (d == KEY_FIRST) ? KS_HALF : KS_LOCKED;
    else if (hit1) kick_next = (cur == KS_HALF && d == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
  endfunction

  // MAC readout word: sel=0 gives bytes 1..4, sel=1 gives bytes 5,6 then zero.
  function automatic logic [31:0] mac_word(logic [47:0] mac, logic sel);
    mac_word = sel ? {mac[15:0], 16'h0000} : mac[47:16];
  endfunction
endpackage

// File: rtl/cgb_kick_fsm.sv
module cgb_kick_fsm
  import cgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit0,
  input  logic        hit1,
  input  logic [31:0] wdata,
  output logic        open
);
  kick_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= kick_next(st_q, hit0, hit1, wdata);
  end

  assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/cgb_devctl.sv
module cgb_devctl #(
  parameter int unsigned NUM_DEV = 12,
  parameter int unsigned FLD_W   = 2,
  parameter int unsigned EN_CODE = 1,
  parameter int unsigned FIX_LSB = 30,
  parameter int unsigned FIX_EN  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rd_word,
  output logic [NUM_DEV-1:0] dev_en,
  output logic               fix_en
);
  localparam int unsigned CTL_W = NUM_DEV * FLD_W;

  logic [CTL_W-1:0] fld_q;
  logic             fix_q;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)  fld_q[g*FLD_W +: FLD_W] <= '0;
      else if (wr) fld_q[g*FLD_W +: FLD_W] <= wdata[g*FLD_W +: FLD_W];
    end
    assign dev_en[g] = (fld_q[g*FLD_W +: FLD_W] == FLD_W'(EN_CODE));
  end

  // The extra device only ever moves to enabled; other codes are ignored.
  always_ff @(posedge clk) begin
    if (!rst_n) fix_q <= 1'b0;
    else if (wr && wdata[FIX_LSB +: FLD_W] == FLD_W'(FIX_EN)) fix_q <= 1'b1;
  end

  always_comb begin
    rd_word = '0;
    rd_word[CTL_W-1:0] = fld_q;
    rd_word[FIX_LSB +: FLD_W] = fix_q ? FLD_W'(FIX_EN) : '0;
  end

  assign fix_en = fix_q;
endmodule

// File: rtl/cgb_wonce.sv
module cgb_wonce #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      done  <= 1'b0;
    end else if (wr && !done) begin
      value <= wdata;
      done  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank
  import cgb_pkg::*;
#(
  parameter int unsigned NUM_DEV = 12,
  parameter int unsigned FLD_W   = 2,
  parameter int unsigned EN_CODE = 1,
  parameter int unsigned FIX_LSB = 30,
  parameter int unsigned FIX_EN  = 3,
  parameter int unsigned WO_W    = 8,
  parameter int unsigned REV_LSB = 28,
  parameter int unsigned REV_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [19:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [REV_W-1:0]   silicon_rev,
  input  logic [47:0]        mac_fuse,
  output logic [NUM_DEV-1:0] dev_en,
  output logic               fix_en,
  output logic               rmii_rst,
  output logic [WO_W-1:0]    wo_cfg,
  output logic               wr_err
);
  // Address decode of the write strobe
  logic hit_k0, hit_k1, hit_lock, hit_dev, hit_rmii, hit_once, prot_hit;
  assign hit_k0   = bus_we && bus_addr == OFF_KICK0;
  assign hit_k1   = bus_we && bus_addr == OFF_KICK1;
  assign hit_lock = bus_we && bus_addr == OFF_LOCK;
  assign hit_dev  = bus_we && bus_addr == OFF_DEVCTL;
  assign hit_rmii = bus_we && bus_addr == OFF_RMII;
  assign hit_once = bus_we && bus_addr == OFF_ONCE;
  assign prot_hit = hit_lock | hit_dev | hit_rmii | hit_once;

  // Kick gate
  logic kick_open;
  cgb_kick_fsm u_kick (
    .clk(clk), .rst_n(rst_n), .hit0(hit_k0), .hit1(hit_k1),
    .wdata(bus_wdata), .open(kick_open)
  );

  // Lock register and per-register acceptance
  logic [31:0] lock_q;
  logic        dev_ok, wo_done, wr_accept, wr_reject;
  assign dev_ok    = kick_open && lock_q == LOCK_KEY;
  assign wr_accept = (hit_lock & kick_open) | (hit_dev & dev_ok) |
                     (hit_rmii & kick_open) | (hit_once & kick_open & ~wo_done);
  assign wr_reject = prot_hit & ~wr_accept;

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= '0;
    else if (hit_lock && kick_open) lock_q <= bus_wdata;
  end

  // Device fields
  logic [31:0] dev_word;
  cgb_devctl #(
    .NUM_DEV(NUM_DEV), .FLD_W(FLD_W), .EN_CODE(EN_CODE),
    .FIX_LSB(FIX_LSB), .FIX_EN(FIX_EN)
  ) u_dev (
    .clk(clk), .rst_n(rst_n), .wr(hit_dev && dev_ok), .wdata(bus_wdata),
    .rd_word(dev_word), .dev_en(dev_en), .fix_en(fix_en)
  );

  // Write-once configuration
  cgb_wonce #(.W(WO_W)) u_once (
    .clk(clk), .rst_n(rst_n), .wr(hit_once && kick_open),
    .wdata(bus_wdata[WO_W-1:0]), .value(wo_cfg), .done(wo_done)
  );

  // RMII reset control and sticky error
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmii_rst <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (hit_rmii && kick_open) rmii_rst <= bus_wdata[RMII_BIT];
      if (wr_reject)      wr_err <= 1'b1;
      else if (wr_accept) wr_err <= 1'b0;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_REV:    bus_rdata[REV_LSB +: REV_W] = silicon_rev;
      OFF_MAC0:   bus_rdata = mac_word(mac_fuse, 1'b0);
      OFF_MAC1:   bus_rdata = mac_word(mac_fuse, 1'b1);
      OFF_LOCK:   bus_rdata = lock_q;
      OFF_DEVCTL: bus_rdata = dev_word;
      OFF_RMII:   bus_rdata[RMII_BIT] = rmii_rst;
      OFF_ONCE:   bus_rdata[WO_W-1:0] = wo_cfg;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cgb_guard_chk.sv
module cgb_guard_chk #(
  parameter int unsigned NUM_DEV = 12,
  parameter int unsigned WO_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               kick_open,
  input logic               wr_accept,
  input logic               wr_reject,
  input logic               wo_done,
  input logic [NUM_DEV-1:0] dev_en,
  input logic               fix_en,
  input logic               rmii_rst,
  input logic [WO_W-1:0]    wo_cfg,
  input logic               wr_err
);
  a_r4_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_err);
  a_r12_accept_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_err);
  a_r2_closed_dev_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_open |=> $stable(dev_en));
  a_r11_closed_rmii_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_open |=> $stable(rmii_rst));
  a_r7_fix_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> fix_en);
  a_r8_once_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wo_done |=> $stable(wo_cfg));
endmodule

bind cfg_guard_bank cgb_guard_chk #(.NUM_DEV(NUM_DEV), .WO_W(WO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick_open(kick_open), .wr_accept(wr_accept),
  .wr_reject(wr_reject), .wo_done(wo_done), .dev_en(dev_en), .fix_en(fix_en),
  .rmii_rst(rmii_rst), .wo_cfg(wo_cfg), .wr_err(wr_err)
);

// File: tb/cfg_guard_bank_tb.sv
module cfg_guard_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  silicon_rev = 4'hB;
  logic [47:0] mac_fuse = 48'h112233445566;
  logic [11:0] dev_en;
  logic        fix_en, rmii_rst, wr_err;
  logic [7:0]  wo_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_guard_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .silicon_rev(silicon_rev),
    .mac_fuse(mac_fuse), .dev_en(dev_en), .fix_en(fix_en), .rmii_rst(rmii_rst),
    .wo_cfg(wo_cfg), .wr_err(wr_err)
  );

  // Observation kinds: 0 read data, 1 dev_en, 2 fix_en, 3 rmii_rst, 4 wr_err, 5 wo_cfg
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [31:0] K1 = 32'h83E70B13;
  localparam logic [31:0] K2 = 32'h95A4F1E0;
  localparam logic [31:0] LK = 32'h0F0A0B00;

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [19:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [19:0] a, input logic [31:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  task automatic pin(input int kind, input logic [31:0] e, input string tag);
    expect_item(kind, 20'h0, e, tag);
  endtask

  task automatic open_gate();
    wr(20'h00038, K1);
    wr(20'h0003C, K2);
  endtask

  // Monitor: pops expected items and compares away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = 32'(dev_en);
        2: act = 32'(fix_en);
        3: act = 32'(rmii_rst);
        4: act = 32'(wr_err);
        default: act = 32'(wo_cfg);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    pin(1, 32'h0, "R1 dev_en after reset");
    pin(2, 32'h0, "R1 fix_en after reset");
    pin(3, 32'h0, "R1 rmii_rst after reset");
    pin(4, 32'h0, "R1 wr_err after reset");
    rd(20'h40008, 32'h0, "R1 devctl after reset");

    // R4 locked writes dropped, reads allowed
    wr(20'h40004, LK);
    rd(20'h40004, 32'h0, "R4 lock write dropped while locked");
    pin(4, 32'h1, "R4 wr_err after locked write");
    rd(20'h00008, 32'hB000_0000, "R4 R9 revision readable while locked");

    // R3 second key first, then probe
    wr(20'h0003C, K2);
    wr(20'h40020, 32'h0004_0000);
    pin(3, 32'h0, "R3 out-of-order kick keeps gate closed");
    // R3 wrong first key
    wr(20'h00038, 32'h0000_1234);
    wr(20'h0003C, K2);
    wr(20'h40020, 32'h0004_0000);
    pin(3, 32'h0, "R3 wrong first key keeps gate closed");
    pin(4, 32'h1, "R12 kick writes leave wr_err set");

    // R2 correct sequence, R11 RMII bit
    open_gate();
    wr(20'h40020, 32'hFFFF_FFFF);
    pin(3, 32'h1, "R2 R11 rmii_rst set after opening");
    rd(20'h40020, 32'h0004_0000, "R11 RMII register other bits zero");
    pin(4, 32'h0, "R12 accepted write clears wr_err");

    // R5 device control needs lock key
    wr(20'h40008, 32'h0000_0001);
    pin(1, 32'h0, "R5 devctl blocked without lock key");
    pin(4, 32'h1, "R5 R12 devctl reject sets wr_err");
    wr(20'h40004, LK);
    rd(20'h40004, LK, "R5 lock register readback");
    pin(4, 32'h0, "R12 lock write accepted clears wr_err");

    // R6 R7 patterns
    wr(20'h40008, 32'hC040_0019);
    pin(1, 32'h805, "R6 dev_en pattern A");
    pin(2, 32'h1, "R7 fix_en set by code 3");
    rd(20'h40008, 32'hC040_0019, "R6 devctl readback A");
    wr(20'h40008, 32'h0055_5555);
    pin(1, 32'hFFF, "R6 dev_en pattern B");
    pin(2, 32'h1, "R7 fix_en not cleared");
    rd(20'h40008, 32'hC055_5555, "R7 fixed field reads 3");
    wr(20'h40008, 32'h80AA_AAAA);
    pin(1, 32'h0, "R6 code 2 is not enable");
    rd(20'h40008, 32'hC0AA_AAAA, "R7 code 2 on fixed field ignored");

    // R5 lock key removed
    wr(20'h40004, 32'h0);
    wr(20'h40008, 32'h0000_0001);
    pin(1, 32'h0, "R5 devctl blocked after lock cleared");

    // R8 write-once
    wr(20'h4002C, 32'h0000_00A5);
    pin(5, 32'hA5, "R8 first write captured");
    wr(20'h4002C, 32'h0000_005A);
    rd(20'h4002C, 32'h0000_00A5, "R8 second write no effect");
    pin(4, 32'h1, "R8 second write sets wr_err");

    // R10 MAC, R9 read-only
    rd(20'h00700, 32'h1122_3344, "R10 MAC bytes 1-4");
    rd(20'h00704, 32'h5566_0000, "R10 MAC bytes 5,6");
    wr(20'h00008, 32'h0);
    rd(20'h00008, 32'hB000_0000, "R9 revision write ignored");

    // R3 wrong key after open relocks
    wr(20'h00038, 32'hDEAD_BEEF);
    wr(20'h40020, 32'h0);
    pin(3, 32'h1, "R3 relock after wrong key");

    // R1 reset releases write-once and clears devices
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    pin(1, 32'h0, "R1 dev_en cleared by reset");
    pin(2, 32'h0, "R1 fix_en cleared by reset");
    wr(20'h40020, 32'h0004_0000);
    pin(3, 32'h0, "R1 gate locked after reset");
    open_gate();
    wr(20'h4002C, 32'h0000_003C);
    pin(5, 32'h3C, "R1 write-once writable after reset");

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule